// File: doc/BRIEF.md
# Multi-Channel Grayscale PWM Generator

This block drives 48 on/off channels, arranged as three colour groups of 16, from one 16-bit grayscale value per channel. A free-running counter, clocked by a dedicated grayscale clock, is shared by every channel. A channel is on while the counter is below that channel's value, so the on-time of each period is proportional to the value.

Grayscale values arrive as one wide word in the system clock domain. They are handed into the grayscale domain through a shadow register and a toggle handshake. The writer must leave the word stable for a few grayscale cycles after each write. A flag that goes with the write asks for a timing restart. When it is set, the outputs are forced off, the counter goes back to zero and the new values start at once. When it is clear, the new values wait for the next period boundary.

To spread supply transients, the channel pairs of each group switch at staggered times, from 0 to 7 grayscale cycles apart. When auto-repeat is enabled, periods follow one another. When it is disabled, the block runs one period and then stays dark. Dot-correction, brightness and current-range codes are only registered and passed through, for the analog stage.

Top module: `gs_pwm_top`

## Requirements
- R1: While reset is held and right after it, every PWM output is 0 and the dot-correction, brightness and current-range outputs are 0.
- R2: While the counter is running, each rising grayscale clock edge adds one to it.
- R3: In every period, each channel is high for exactly as many grayscale cycles as its value. A value of 1 gives a single high cycle.
- R4: A value of 0 keeps a channel low for the whole period. The largest value (all ones) keeps it high for all cycles of the period but one.
- R5: Channel i of a group (i = 0..15) is delayed by d grayscale cycles relative to the undelayed PWM, where d depends only on min(i, 15-i). The values 4, 0, 5, 1, 2, 6, 3, 7 of min(i, 15-i) give d = 0, 1, 2, 3, 4, 5, 6, 7 in that order. Channel ch belongs to group ch/16 and has index i = ch mod 16. Word bits [ch*W +: W] hold its value.
- R6: A write with the timing-restart flag set has three effects. On the following grayscale cycle, all outputs are low and the counter is 0. The counter runs again from 0. The newly written values apply from the first count.
- R7: With auto-repeat high, the counter wraps from its maximum to 0 and a new period starts without a gap.
- R8: With auto-repeat low, the counter stops at the end of the period. All outputs then stay low until the next timing restart.
- R9: A write without the timing-restart flag takes effect at the next period start, so no period mixes old and new values.
- R10: After reset, as long as no grayscale data has been written, all outputs stay low.
- R11: The dot-correction, brightness and current-range outputs take their inputs one system clock after a code write strobe, and hold them otherwise.
- R12: A write without the timing-restart flag does not restart or shift the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock for the write side and the code registers |
| gsClk | input | 1 | Grayscale counter clock |
| rstN | input | 1 | Active-low synchronous reset, seen in both domains |
| gsWrEn | input | 1 | Write strobe for the grayscale word (system domain) |
| gsWrData | input | NUM_CH*CNT_W | One CNT_W-bit value per channel, channel ch at bits [ch*CNT_W +: CNT_W] |
| gsWrTmgRst | input | 1 | With gsWrEn, asks for a timing restart |
| autoRepeat | input | 1 | 1: periods repeat; 0: one period, then stop |
| codeWrEn | input | 1 | Write strobe for the pass-through codes |
| dotCorrIn | input | NUM_CH*DC_W | Per-channel dot-correction codes |
| brightIn | input | NUM_GROUPS*BC_W | Per-group brightness codes |
| maxCurIn | input | NUM_GROUPS*MC_W | Per-group current-range codes |
| dotCorrOut | output | NUM_CH*DC_W | Registered dot-correction codes |
| brightOut | output | NUM_GROUPS*BC_W | Registered brightness codes |
| maxCurOut | output | NUM_GROUPS*MC_W | Registered current-range codes |
| pwmOut | output | NUM_CH | One on/off PWM bit per channel |

## Verification
The bench counts high cycles per channel in a one-shot period with random values mixed with 0, 1 and the maximum. This separates correct compare limits from off-by-one and stuck channels. A count over three repeated periods separates wrapping from stopping. The first rising edge of each channel, taken relative to the earliest one when all values are equal, shows whether each pair has its own stagger delay. A write without restart, dropped at a random phase of a running sequence, is checked pulse by pulse and gap by gap. Any split period, or any restart of the counter, gives a pulse or gap length that fits neither the old nor the new value.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;

  // Channels per colour group and depth of the stagger line.
  localparam int unsigned GROUP_SIZE    = 16;
  localparam int unsigned STAGGER_DEPTH = 8;

  // Strobes from the control to the datapath (grayscale domain).
  typedef struct packed {
    logic capture;  // take the shadow word into the pending buffer
    logic load;     // move pending values into the active set
    logic clear;    // flush the stagger line (outputs off)
    logic run;      // counter is inside a period
  } gsStrobe_t;

  // Stagger delay of a channel, from its index inside the group.
  function automatic int unsigned pairDelay(input int unsigned idxInGroup);
    int unsigned mirror;
    mirror = (idxInGroup < GROUP_SIZE / 2) ? idxInGroup : (GROUP_SIZE - 1 - idxInGroup);
    case (mirror)
      0:       pairDelay = 1;
      1:       pairDelay = 3;
      2:       pairDelay = 4;
      3:       pairDelay = 6;
      4:       pairDelay = 0;
      5:       pairDelay = 2;
      6:       pairDelay = 5;
      default: pairDelay = 7;
    endcase
  endfunction

endpackage

// File: rtl/gs_pwm_wrport.sv
module gs_pwm_wrport #(
  parameter int unsigned NUM_CH     = 48,
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DC_W       = 7,
  parameter int unsigned BC_W       = 7,
  parameter int unsigned MC_W       = 3
) (
  input  logic                       sysClk,
  input  logic                       rstN,
  input  logic                       gsWrEn,
  input  logic [NUM_CH*CNT_W-1:0]    gsWrData,
  input  logic                       gsWrTmgRst,
  input  logic                       codeWrEn,
  input  logic [NUM_CH*DC_W-1:0]     dotCorrIn,
  input  logic [NUM_GROUPS*BC_W-1:0] brightIn,
  input  logic [NUM_GROUPS*MC_W-1:0] maxCurIn,
  output logic [NUM_CH*CNT_W-1:0]    shadowData,
  output logic                       shadowTmg,
  output logic                       reqTgl,
  output logic [NUM_CH*DC_W-1:0]     dotCorrOut,
  output logic [NUM_GROUPS*BC_W-1:0] brightOut,
  output logic [NUM_GROUPS*MC_W-1:0] maxCurOut
);

  // Shadow word and request toggle; the toggle is the only bit that
  // crosses through a synchronizer, the word is sampled once it is stable.
  always_ff @(posedge sysClk) begin
    if (!rstN) begin
      shadowData <= '0;
      shadowTmg  <= 1'b0;
      reqTgl     <= 1'b0;
    end else if (gsWrEn) begin
      shadowData <= gsWrData;
      shadowTmg  <= gsWrTmgRst;
      reqTgl     <= ~reqTgl;
    end
  end

  // Pass-through code registers for the analog current stage.
  always_ff @(posedge sysClk) begin
    if (!rstN) begin
      dotCorrOut <= '0;
      brightOut  <= '0;
      maxCurOut  <= '0;
    end else if (codeWrEn) begin
      dotCorrOut <= dotCorrIn;
      brightOut  <= brightIn;
      maxCurOut  <= maxCurIn;
    end
  end

endmodule

// File: rtl/gs_pwm_ctrl.sv
module gs_pwm_ctrl
  import gs_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             gsClk,
  input  logic             rstN,
  input  logic             reqTgl,
  input  logic             shadowTmg,
  input  logic             autoRepeat,
  output gsStrobe_t        strb,
  output logic [CNT_W-1:0] cnt,
  output logic             repeatOn
);

  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  logic [2:0]       tglSync;   // [1:0] synchronizer, [2] previous value
  logic [1:0]       repSync;
  logic             pendValid;
  logic             tmgFire;
  logic             running;
  logic [CNT_W-1:0] cntQ;
  logic             newReq;
  logic             atLast;
  logic             wrapLoad;

  assign newReq   = tglSync[1] ^ tglSync[2];
  assign atLast   = running && (cntQ == CNT_LAST);
  assign wrapLoad = atLast && repSync[1] && pendValid && !tmgFire;

  always_ff @(posedge gsClk) begin
    if (!rstN) begin
      tglSync   <= '0;
      repSync   <= '0;
      pendValid <= 1'b0;
      tmgFire   <= 1'b0;
      running   <= 1'b1;
      cntQ      <= '0;
    end else begin
      tglSync <= {tglSync[1:0], reqTgl};
      repSync <= {repSync[0], autoRepeat};
      tmgFire <= newReq && shadowTmg;
      if (tmgFire) begin
        cntQ      <= '0;
        running   <= 1'b1;
        pendValid <= 1'b0;
      end else begin
        if (newReq) begin
          pendValid <= 1'b1;
        end else if (wrapLoad) begin
          pendValid <= 1'b0;
        end
        if (running) begin
          if (cntQ == CNT_LAST) begin
            if (repSync[1]) begin
              cntQ <= '0;
            end else begin
              running <= 1'b0;
            end
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strb.capture = newReq;
    strb.load    = tmgFire | wrapLoad;
    strb.clear   = tmgFire;
    strb.run     = running;
  end

  assign cnt      = cntQ;
  assign repeatOn = repSync[1];

endmodule

// File: rtl/gs_pwm_datapath.sv
module gs_pwm_datapath
  import gs_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 48,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                    gsClk,
  input  logic                    rstN,
  input  gsStrobe_t               strb,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [NUM_CH*CNT_W-1:0] shadowData,
  output logic [NUM_CH*CNT_W-1:0] activeVals,
  output logic [NUM_CH-1:0]       pwmOut
);

  logic [NUM_CH*CNT_W-1:0] pendQ;
  logic [NUM_CH*CNT_W-1:0] actQ;
  logic [NUM_CH-1:0]       rawOn;
  logic [NUM_CH-1:0]       dlyQ [STAGGER_DEPTH];

  // Pending buffer: filled from the shadow once the toggle is seen.
  always_ff @(posedge gsClk) begin
    if (!rstN) begin
      pendQ <= '0;
    end else if (strb.capture) begin
      pendQ <= shadowData;
    end
  end

  // Active set: changes only at a period start or on a timing restart.
  always_ff @(posedge gsClk) begin
    if (!rstN) begin
      actQ <= '0;
    end else if (strb.load) begin
      actQ <= pendQ;
    end
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
      assign rawOn[ch] = strb.run && (cnt < actQ[ch*CNT_W +: CNT_W]);
    end
  endgenerate

  // Stagger line: stage k holds the compare result k+1 cycles old.
  always_ff @(posedge gsClk) begin
    if (!rstN || strb.clear) begin
      for (int k = 0; k < STAGGER_DEPTH; k++) begin
        dlyQ[k] <= '0;
      end
    end else begin
      dlyQ[0] <= rawOn;
      for (int k = 1; k < STAGGER_DEPTH; k++) begin
        dlyQ[k] <= dlyQ[k-1];
      end
    end
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_tap
      localparam int unsigned TAP = pairDelay(ch % GROUP_SIZE);
      assign pwmOut[ch] = dlyQ[TAP][ch];
    end
  endgenerate

  assign activeVals = actQ;

endmodule

// File: rtl/gs_pwm_top.sv
module gs_pwm_top
  import gs_pwm_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DC_W       = 7,
  parameter int unsigned BC_W       = 7,
  parameter int unsigned MC_W       = 3,
  localparam int unsigned NUM_CH    = NUM_GROUPS * GROUP_SIZE
) (
  input  logic                       sysClk,
  input  logic                       gsClk,
  input  logic                       rstN,
  input  logic                       gsWrEn,
  input  logic [NUM_CH*CNT_W-1:0]    gsWrData,
  input  logic                       gsWrTmgRst,
  input  logic                       autoRepeat,
  input  logic                       codeWrEn,
  input  logic [NUM_CH*DC_W-1:0]     dotCorrIn,
  input  logic [NUM_GROUPS*BC_W-1:0] brightIn,
  input  logic [NUM_GROUPS*MC_W-1:0] maxCurIn,
  output logic [NUM_CH*DC_W-1:0]     dotCorrOut,
  output logic [NUM_GROUPS*BC_W-1:0] brightOut,
  output logic [NUM_GROUPS*MC_W-1:0] maxCurOut,
  output logic [NUM_CH-1:0]          pwmOut
);

  logic [NUM_CH*CNT_W-1:0] shadowData;
  logic                    shadowTmg;
  logic                    reqTgl;
  gsStrobe_t               gsStrb;
  logic [CNT_W-1:0]        gsCnt;
  logic                    repeatOn;
  logic [NUM_CH*CNT_W-1:0] activeVals;

  gs_pwm_wrport #(
    .NUM_CH(NUM_CH), .NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W),
    .DC_W(DC_W), .BC_W(BC_W), .MC_W(MC_W)
  ) u_wrport (
    .sysClk(sysClk), .rstN(rstN),
    .gsWrEn(gsWrEn), .gsWrData(gsWrData), .gsWrTmgRst(gsWrTmgRst),
    .codeWrEn(codeWrEn), .dotCorrIn(dotCorrIn), .brightIn(brightIn), .maxCurIn(maxCurIn),
    .shadowData(shadowData), .shadowTmg(shadowTmg), .reqTgl(reqTgl),
    .dotCorrOut(dotCorrOut), .brightOut(brightOut), .maxCurOut(maxCurOut)
  );

  gs_pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .gsClk(gsClk), .rstN(rstN), .reqTgl(reqTgl), .shadowTmg(shadowTmg),
    .autoRepeat(autoRepeat), .strb(gsStrb), .cnt(gsCnt), .repeatOn(repeatOn)
  );

  gs_pwm_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .gsClk(gsClk), .rstN(rstN), .strb(gsStrb), .cnt(gsCnt),
    .shadowData(shadowData), .activeVals(activeVals), .pwmOut(pwmOut)
  );

endmodule

// File: rtl/gs_pwm_checker.sv
module gs_pwm_checker
  import gs_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH     = 48,
  parameter int unsigned NUM_GROUPS = 3,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DC_W       = 7,
  parameter int unsigned BC_W       = 7,
  parameter int unsigned MC_W       = 3
) (
  input logic                       sysClk,
  input logic                       gsClk,
  input logic                       rstN,
  input gsStrobe_t                  strb,
  input logic [CNT_W-1:0]           cnt,
  input logic                       repeatOn,
  input logic [NUM_CH*CNT_W-1:0]    activeVals,
  input logic [NUM_CH-1:0]          pwmOut,
  input logic                       codeWrEn,
  input logic [NUM_CH*DC_W-1:0]     dotCorrIn,
  input logic [NUM_GROUPS*BC_W-1:0] brightIn,
  input logic [NUM_GROUPS*MC_W-1:0] maxCurIn,
  input logic [NUM_CH*DC_W-1:0]     dotCorrOut,
  input logic [NUM_GROUPS*BC_W-1:0] brightOut,
  input logic [NUM_GROUPS*MC_W-1:0] maxCurOut
);

  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  // R2: one step per edge inside a period
  a_r2_count_step: assert property (@(posedge gsClk) disable iff (!rstN)
    (strb.run && !strb.clear && cnt != CNT_LAST) |=> (strb.run && cnt == CNT_W'($past(cnt) + 1'b1)));

  // R6: restart forces outputs off and zeroes the counter
  a_r6_restart_dark: assert property (@(posedge gsClk) disable iff (!rstN)
    strb.clear |=> (pwmOut == '0 && cnt == '0 && strb.run));

  // R7: wrap at the last step when repeating
  a_r7_wrap: assert property (@(posedge gsClk) disable iff (!rstN)
    (strb.run && !strb.clear && cnt == CNT_LAST && repeatOn) |=> (strb.run && cnt == '0));

  // R8: a stopped counter stays put until a restart
  a_r8_stopped_hold: assert property (@(posedge gsClk) disable iff (!rstN)
    (!strb.run && !strb.clear) |=> (!strb.run && $stable(cnt)));

  // R9: active values switch only at a period start
  a_r9_load_at_start: assert property (@(posedge gsClk) disable iff (!rstN)
    strb.load |=> (cnt == '0));

  // R9: no change of the active set without a load
  a_r9_active_hold: assert property (@(posedge gsClk) disable iff (!rstN)
    !strb.load |=> $stable(activeVals));

  // R11: codes follow the inputs on a write strobe
  a_r11_code_load: assert property (@(posedge sysClk) disable iff (!rstN)
    codeWrEn |=> (dotCorrOut == $past(dotCorrIn) && brightOut == $past(brightIn)
                  && maxCurOut == $past(maxCurIn)));

  // R11: codes hold without a write strobe
  a_r11_code_hold: assert property (@(posedge sysClk) disable iff (!rstN)
    !codeWrEn |=> ($stable(dotCorrOut) && $stable(brightOut) && $stable(maxCurOut)));

endmodule

bind gs_pwm_top gs_pwm_checker #(
  .NUM_CH(NUM_CH), .NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W),
  .DC_W(DC_W), .BC_W(BC_W), .MC_W(MC_W)
) u_chk (
  .sysClk(sysClk), .gsClk(gsClk), .rstN(rstN),
  .strb(gsStrb), .cnt(gsCnt), .repeatOn(repeatOn),
  .activeVals(activeVals), .pwmOut(pwmOut),
  .codeWrEn(codeWrEn), .dotCorrIn(dotCorrIn), .brightIn(brightIn), .maxCurIn(maxCurIn),
  .dotCorrOut(dotCorrOut), .brightOut(brightOut), .maxCurOut(maxCurOut)
);

// File: tb/test_gs_pwm_top.sv
`timescale 1ns/1ps
module test_gs_pwm_top;

  localparam int NUM_GROUPS = 3;
  localparam int NUM_CH     = NUM_GROUPS * 16;
  localparam int CNT_W      = 6;
  localparam int PER        = 1 << CNT_W;
  localparam int DC_W = 7, BC_W = 7, MC_W = 3;

  logic sysClk = 1'b0, gsClk = 1'b0, rstN = 1'b0;
  logic gsWrEn = 1'b0, gsWrTmgRst = 1'b0, autoRepeat = 1'b1, codeWrEn = 1'b0;
  logic [NUM_CH*CNT_W-1:0]    gsWrData = '0;
  logic [NUM_CH*DC_W-1:0]     dotCorrIn = '0;
  logic [NUM_GROUPS*BC_W-1:0] brightIn = '0;
  logic [NUM_GROUPS*MC_W-1:0] maxCurIn = '0;
  logic [NUM_CH*DC_W-1:0]     dotCorrOut;
  logic [NUM_GROUPS*BC_W-1:0] brightOut;
  logic [NUM_GROUPS*MC_W-1:0] maxCurOut;
  logic [NUM_CH-1:0]          pwmOut;

  always #10 sysClk = ~sysClk;  // 50 MHz
  always #7  gsClk  = ~gsClk;

  gs_pwm_top #(.NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W), .DC_W(DC_W), .BC_W(BC_W), .MC_W(MC_W)) i_gs_pwm_top (
    .sysClk(sysClk), .gsClk(gsClk), .rstN(rstN),
    .gsWrEn(gsWrEn), .gsWrData(gsWrData), .gsWrTmgRst(gsWrTmgRst), .autoRepeat(autoRepeat),
    .codeWrEn(codeWrEn), .dotCorrIn(dotCorrIn), .brightIn(brightIn), .maxCurIn(maxCurIn),
    .dotCorrOut(dotCorrOut), .brightOut(brightOut), .maxCurOut(maxCurOut), .pwmOut(pwmOut)
  );

  int nChecks = 0, nFail = 0, gsTick = 0;
  int hiCnt[NUM_CH], firstRise[NUM_CH], runLen[NUM_CH], lastPulse[NUM_CH];
  int badPulse[NUM_CH], badGap[NUM_CH], valA[NUM_CH], valB[NUM_CH];
  bit prevOut[NUM_CH], seenEdge[NUM_CH];
  bit pulseChk = 0;
  int seedDummy;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Stagger expected from the pair order list (R5).
  function automatic int expDelay(input int ch);
    int order[8] = '{4, 0, 5, 1, 2, 6, 3, 7};
    int idx = ch % 16;
    int low = (idx < 8) ? idx : 15 - idx;
    for (int k = 0; k < 8; k++) if (order[k] == low) return k;
    return -1;
  endfunction

  function automatic logic [NUM_CH*CNT_W-1:0] packVals(input int v[NUM_CH]);
    logic [NUM_CH*CNT_W-1:0] w = '0;
    for (int ch = 0; ch < NUM_CH; ch++) w[ch*CNT_W +: CNT_W] = CNT_W'(v[ch]);
    return w;
  endfunction

  task automatic clearStats();
    for (int ch = 0; ch < NUM_CH; ch++) begin
      hiCnt[ch] = 0; firstRise[ch] = -1; runLen[ch] = 0; lastPulse[ch] = -1;
      badPulse[ch] = 0; badGap[ch] = 0; seenEdge[ch] = 0;
    end
  endtask

  task automatic observe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge gsClk);
      gsTick++;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (pwmOut[ch]) hiCnt[ch]++;
        if (pwmOut[ch] && !prevOut[ch] && firstRise[ch] < 0) firstRise[ch] = gsTick;
        if (pulseChk) begin
          if (pwmOut[ch] == prevOut[ch]) runLen[ch]++;
          else begin
            if (seenEdge[ch]) begin
              if (prevOut[ch]) begin
                lastPulse[ch] = runLen[ch];
                if (runLen[ch] != valA[ch] && runLen[ch] != valB[ch]) badPulse[ch]++;
              end else if (runLen[ch] != PER - valA[ch] && runLen[ch] != PER - valB[ch]) badGap[ch]++;
            end
            seenEdge[ch] = 1;
            runLen[ch] = 1;
          end
        end
        prevOut[ch] = pwmOut[ch];
      end
    end
  endtask

  task automatic writeGs(input int v[NUM_CH], input bit tmg);
    @(negedge sysClk);
    gsWrData = packVals(v);
    gsWrTmgRst = tmg;
    gsWrEn = 1'b1;
    @(negedge sysClk);
    gsWrEn = 1'b0;
  endtask

  task automatic setRepeat(input bit r);
    @(negedge sysClk);
    autoRepeat = r;
    observe(10);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", gsTick, 0);
    summary();
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'd5955);
    for (int ch = 0; ch < NUM_CH; ch++) prevOut[ch] = 0;
    clearStats();
    repeat (6) @(negedge sysClk);
    // R1: outputs while reset is held
    check(pwmOut == '0, "R1 pwm in reset", longint'(pwmOut), 0);
    rstN = 1'b1;
    @(negedge sysClk);
    check(pwmOut == '0, "R1 pwm after reset", longint'(pwmOut), 0);
    check(dotCorrOut == '0 && brightOut == '0 && maxCurOut == '0, "R1 codes after reset",
          longint'(brightOut), 0);

    // R10: no data written, repeat on, several periods dark
    clearStats();
    observe(5 * PER);
    begin
      int tot = 0;
      for (int ch = 0; ch < NUM_CH; ch++) tot += hiCnt[ch];
      check(tot == 0, "R10 idle dark", tot, 0);
    end

    // R11: code pass-through, load then hold
    begin
      logic [NUM_CH*DC_W-1:0] dcExp;
      logic [NUM_GROUPS*BC_W-1:0] bcExp;
      logic [NUM_GROUPS*MC_W-1:0] mcExp;
      @(negedge sysClk);
      for (int k = 0; k < NUM_CH*DC_W; k++) dotCorrIn[k] = $urandom % 2;
      brightIn = NUM_GROUPS*BC_W'($urandom);
      maxCurIn = NUM_GROUPS*MC_W'($urandom);
      dcExp = dotCorrIn; bcExp = brightIn; mcExp = maxCurIn;
      codeWrEn = 1'b1;
      @(negedge sysClk);
      codeWrEn = 1'b0;
      check(dotCorrOut == dcExp, "R11 dot-corr load", longint'(dotCorrOut[63:0]), longint'(dcExp[63:0]));
      check(brightOut == bcExp && maxCurOut == mcExp, "R11 group codes load", longint'(brightOut), longint'(bcExp));
      dotCorrIn = ~dotCorrIn; brightIn = ~brightIn; maxCurIn = ~maxCurIn;
      repeat (3) @(negedge sysClk);
      check(dotCorrOut == dcExp && brightOut == bcExp && maxCurOut == mcExp, "R11 hold without strobe",
            longint'(brightOut), longint'(bcExp));
    end

    // R3/R4/R6/R8: one-shot period with random and directed values
    setRepeat(1'b0);
    for (int ch = 0; ch < NUM_CH; ch++) valA[ch] = $urandom % PER;
    valA[0] = 0; valA[17] = 1; valA[33] = PER - 1; valA[47] = 0; valA[4] = PER - 1;
    clearStats();
    writeGs(valA, 1'b1);
    observe(PER + 40);
    for (int ch = 0; ch < NUM_CH; ch++)
      check(hiCnt[ch] == valA[ch], (valA[ch] == 0 || valA[ch] == PER - 1) ? "R4 edge value on-time" :
            "R3 R2 R6 one-shot on-time", hiCnt[ch], valA[ch]);
    check(pwmOut == '0, "R8 dark after stop", longint'(pwmOut), 0);
    clearStats();
    observe(3 * PER);
    begin
      int tot = 0;
      for (int ch = 0; ch < NUM_CH; ch++) tot += hiCnt[ch];
      check(tot == 0, "R8 stays dark", tot, 0);
    end

    // R5: equal values, rise offsets against the earliest channel
    for (int ch = 0; ch < NUM_CH; ch++) valA[ch] = 5;
    clearStats();
    writeGs(valA, 1'b1);
    observe(PER + 40);
    begin
      int first = 1 << 30;
      for (int ch = 0; ch < NUM_CH; ch++) if (firstRise[ch] >= 0 && firstRise[ch] < first) first = firstRise[ch];
      for (int ch = 0; ch < NUM_CH; ch++)
        check(firstRise[ch] - first == expDelay(ch), "R5 stagger offset", firstRise[ch] - first, expDelay(ch));
    end

    // R7: repeating periods, three full periods counted
    setRepeat(1'b1);
    for (int ch = 0; ch < NUM_CH; ch++) valA[ch] = $urandom % PER;
    valA[1] = PER - 1; valA[20] = 0;
    writeGs(valA, 1'b1);
    observe(40);
    clearStats();
    observe(3 * PER);
    for (int ch = 0; ch < NUM_CH; ch++)
      check(hiCnt[ch] == 3 * valA[ch], "R7 repeat on-time", hiCnt[ch], 3 * valA[ch]);

    // R9/R12: update without restart at a random phase
    for (int ch = 0; ch < NUM_CH; ch++) begin
      valA[ch] = 5 + ($urandom % 26);
      valB[ch] = valA[ch] + 17;
    end
    writeGs(valA, 1'b1);
    observe(2 * PER);
    clearStats();
    pulseChk = 1;
    observe(1 + ($urandom % PER));
    fork
      writeGs(valB, 1'b0);
      observe(4 * PER);
    join
    pulseChk = 0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      check(badPulse[ch] == 0, "R9 no split period", badPulse[ch], 0);
      check(badGap[ch] == 0, "R12 counter phase kept", badGap[ch], 0);
      check(lastPulse[ch] == valB[ch], "R9 new value adopted", lastPulse[ch], valB[ch]);
    end

    summary();
    $finish;
  end

endmodule